// File: doc/BRIEF.md
# Decimating Circular Sample Buffer

This block sits between two stages of a multirate filter chain and holds the samples that one multiply-accumulate filter of `TAPS` coefficients works on. Samples arrive one at a time on a write port and land in a circular register file. A filter sequencer then pulls each window of `TAPS` samples, one per request, and gets them back on a registered read port one cycle later. The register file has one write port and one read port, and both can be used in the same cycle.

The block decimates by two without computing any output that is later thrown away. After a complete window, the window start moves forward by two entries, so each output the filter builds is one that the decimated stream keeps. At reset the file holds `TAPS-1` zeros ahead of the write position. The first window therefore holds the first real sample together with the leading zero padding. A ready flag tells the sequencer when a full window is available. A sticky error flag reports any sample that was refused because the file held no free entry.

Top module: `decim_sample_buf`

## Requirements
- R1: Directly after reset, `ready`, `rd_vld`, `rd_last` and `ovf_err` are all 0.
- R2: Each accepted sample is stored at the entry after the previous one. The write position wraps from entry `DEPTH-1` back to entry 0, and the stream order is kept across the wrap.
- R3: A sample offered while all `DEPTH` entries hold unconsumed data is dropped and does not appear in any later window. `ovf_err` goes to 1 in the following cycle and stays at 1 until reset.
- R4: The fill level starts at `TAPS-1`. It rises by one for each accepted sample and falls by two at the end of each window. `ready` is 1 exactly when the fill level is at least `TAPS`.
- R5: The first window after reset returns `TAPS-1` zeros followed by the first written sample.
- R6: A request accepted at a clock edge gives `rd_vld`=1 and its sample on `rd_data` after that edge. `rd_last` is 1 only with the `TAPS`-th sample of a window.
- R7: Counting the padded stream from position 0, window j returns the stream positions 2j to 2j+TAPS-1, in rising order.
- R8: Read positions are taken modulo `DEPTH`, so a window that runs past the last entry continues at entry 0.
- R9: A request made while no window is in progress and `ready` is 0 is ignored. It produces no `rd_vld` and does not move the window.
- R10: A write and a read in the same cycle both take effect, and the written sample takes its place in stream order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A sample is offered this cycle |
| wr_data | input | DW | Sample value |
| rd_req | input | 1 | Sequencer asks for the next tap sample |
| rd_data | output | DW | Registered sample of the last accepted request |
| rd_vld | output | 1 | `rd_data` holds a requested sample |
| rd_last | output | 1 | The sample on `rd_data` closes its window |
| ready | output | 1 | A full window is available |
| ovf_err | output | 1 | Sticky: a sample was refused because the file was full |

## Verification
The bench uses `TAPS`=9 and `DW`=16, so `DEPTH` is 17. With that depth, the window start passes the end of the file after the fifth output. The write position wraps after nine samples, and the file fills completely after nine writes with no reads. Wrap-around of both the windows and the write position, and overflow with the dropped sample absent from later windows, all show up within a few dozen samples.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    // Add two values that are each below m, then fold the sum back below m.
    function automatic int unsigned mod_add(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned m);
        int unsigned s;
        s = a + b;
        if (s >= m) s = s - m;
        return s;
    endfunction

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_BURST = 1'b1
    } rd_phase_e;

endpackage

// File: rtl/dsb_regfile.sv
module dsb_regfile #(
    parameter int DW    = 16,
    parameter int DEPTH = 17,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_vld
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            rdata;
        logic                     rvld;
    } rf_st_t;

    rf_st_t st_d, st_q;

    // Reading sees the value held before this edge's write.
    always_comb begin
        st_d      = st_q;
        st_d.rvld = rd_en;
        if (rd_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (rd_addr == AW'(i)) st_d.rdata = st_q.mem[i];
            end
        end
        if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_addr == AW'(i)) st_d.mem[i] = wr_data;
            end
        end
    end

    // Reset clears every entry, which provides the leading zero padding.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign rd_vld  = st_q.rvld;

    p_addr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < AW'(DEPTH)));

    p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < AW'(DEPTH)));

    // A live entry is never written while it is being read.
    p_no_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_addr != wr_addr));

endmodule

// File: rtl/dsb_wr_ctrl.sv
module dsb_wr_ctrl #(
    parameter int TAPS  = 9,
    parameter int DEPTH = 17,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          release_i,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          ready,
    output logic          ovf_err
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] fill;
        logic          ovf;
    } wc_st_t;

    wc_st_t st_d, st_q;
    logic   accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_valid && (st_q.fill != CW'(DEPTH));
        if (accept) begin
            st_d.ptr = AW'(dsb_pkg::mod_add(32'(st_q.ptr), 1, DEPTH));
        end
        if (wr_valid && !accept) st_d.ovf = 1'b1;
        st_d.fill = st_q.fill + CW'(accept) - (release_i ? CW'(2) : CW'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr  <= AW'(TAPS - 1);
            st_q.fill <= CW'(TAPS - 1);
            st_q.ovf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = accept;
    assign wr_addr = st_q.ptr;
    assign ready   = (st_q.fill >= CW'(TAPS));
    assign ovf_err = st_q.ovf;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= CW'(DEPTH));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr < AW'(DEPTH));

    // The sequencer only closes a window that was fully available.
    p_release_needs_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> (st_q.fill >= CW'(TAPS)));

    p_fill_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill >= CW'(TAPS - 2));

endmodule

// File: rtl/dsb_rd_seq.sv
module dsb_rd_seq #(
    parameter int TAPS  = 9,
    parameter int DEPTH = 17,
    parameter int AW    = $clog2(DEPTH),
    parameter int TW    = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          ready,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          release_o,
    output logic          rd_last
);

    typedef struct packed {
        dsb_pkg::rd_phase_e phase;
        logic [TW-1:0]      tap;
        logic [AW-1:0]      base;
        logic               last;
    } rs_st_t;

    rs_st_t st_d, st_q;
    logic   step;
    logic   final_tap;

    always_comb begin
        st_d      = st_q;
        step      = rd_req && ((st_q.phase == dsb_pkg::RD_BURST) || ready);
        final_tap = (st_q.tap == TW'(TAPS - 1));
        rd_addr   = AW'(dsb_pkg::mod_add(32'(st_q.base), 32'(st_q.tap), DEPTH));
        st_d.last = step && final_tap;
        if (step) begin
            if (final_tap) begin
                st_d.tap   = '0;
                st_d.phase = dsb_pkg::RD_IDLE;
                st_d.base  = AW'(dsb_pkg::mod_add(32'(st_q.base), 2, DEPTH));
            end else begin
                st_d.tap   = st_q.tap + TW'(1);
                st_d.phase = dsb_pkg::RD_BURST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= dsb_pkg::RD_IDLE;
            st_q.tap   <= '0;
            st_q.base  <= '0;
            st_q.last  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en     = step;
    assign release_o = step && final_tap;
    assign rd_last   = st_q.last;

    p_tap_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tap < TW'(TAPS));

    p_idle_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == dsb_pkg::RD_IDLE) |-> (st_q.tap == '0));

    p_base_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (st_q.base != $past(st_q.base)));

    p_base_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !release_o |=> $stable(st_q.base));

endmodule

// File: rtl/decim_sample_buf.sv
module decim_sample_buf #(
    parameter int TAPS  = 9,
    parameter int DW    = 16,
    parameter int DEPTH = 2 * TAPS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_vld,
    output logic          rd_last,
    output logic          ready,
    output logic          ovf_err
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int TW = $clog2(TAPS);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          win_done;

    dsb_wr_ctrl #(.TAPS(TAPS), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .release_i (win_done),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .ready     (ready),
        .ovf_err   (ovf_err)
    );

    dsb_rd_seq #(.TAPS(TAPS), .DEPTH(DEPTH), .AW(AW), .TW(TW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .ready     (ready),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .release_o (win_done),
        .rd_last   (rd_last)
    );

    dsb_regfile #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_vld  (rd_vld)
    );

    // A fresh burst of read data only starts after a cycle with a full window.
    p_burst_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_vld) |-> $past(ready));

    p_last_with_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_vld);

endmodule

// File: tb/sim_decim_sample_buf.sv
module sim_decim_sample_buf;

    localparam int TAPS  = 9;
    localparam int DW    = 16;
    localparam int DEPTH = 2 * TAPS - 1;

    // Each row: sample value, expected ready after the write.
    localparam logic [16:0] VEC [0:15] = '{
        {16'h1001, 1'b1}, {16'h2002, 1'b0}, {16'h3003, 1'b1}, {16'h4004, 1'b0},
        {16'h5a05, 1'b1}, {16'h6b06, 1'b0}, {16'h7c07, 1'b1}, {16'h8d08, 1'b0},
        {16'h9e09, 1'b1}, {16'hAf0a, 1'b0}, {16'hB00b, 1'b1}, {16'hC10c, 1'b0},
        {16'hD20d, 1'b1}, {16'hE30e, 1'b0}, {16'hF40f, 1'b1}, {16'h0510, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_vld, rd_last, ready, ovf_err;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] stream [0:127];
    int n_str;
    int n_out;

    always #5 clk = ~clk;

    decim_sample_buf #(.TAPS(TAPS), .DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .rd_vld(rd_vld), .rd_last(rd_last),
        .ready(ready), .ovf_err(ovf_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_fill();
        return n_str - 2 * n_out;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
        for (int i = 0; i < 128; i++) stream[i] = '0;
        n_str = TAPS - 1;
        n_out = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        if (model_fill() < DEPTH) begin
            stream[n_str] = d;
            n_str++;
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic tap_chk(input string tag, input logic [DW-1:0] exp, input bit last);
        chk("R6 rd_vld", int'(rd_vld), 1);
        chk(tag, int'(rd_data), int'(exp));
        chk("R6 rd_last", int'(rd_last), int'(last));
    endtask

    task automatic read_window(input string tag, input bit with_wr, input logic [DW-1:0] wd);
        int base;
        base = 2 * n_out;
        if (with_wr) begin
            stream[n_str] = wd;
            n_str++;
        end
        for (int k = 0; k < TAPS; k++) begin
            @(negedge clk);
            if (k > 0) tap_chk(tag, stream[base + k - 1], 1'b0);
            rd_req   = 1'b1;
            wr_valid = with_wr && (k == 3);
            wr_data  = wd;
        end
        @(negedge clk);
        tap_chk(tag, stream[base + TAPS - 1], 1'b1);
        rd_req = 1'b0; wr_valid = 1'b0;
        n_out++;
        @(negedge clk);
        chk("R4 ready after window", int'(ready), int'(model_fill() >= TAPS));
        chk("R6 idle after window", int'(rd_vld), 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 ready", int'(ready), 0);
        chk("R1 rd_vld", int'(rd_vld), 0);
        chk("R1 rd_last", int'(rd_last), 0);
        chk("R1 ovf_err", int'(ovf_err), 0);

        // R9: requests without a full window are ignored
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); chk("R9 no data", int'(rd_vld), 0);
        @(negedge clk); chk("R9 no data", int'(rd_vld), 0);
        rd_req = 1'b0;

        // Table walk: R4 ready, R5 first window, R7 stepping, R8 wrap
        for (int i = 0; i < 16; i++) begin
            do_write(VEC[i][16:1]);
            chk("R4 ready", int'(ready), int'(VEC[i][0]));
            if (ready) begin
                if (n_out == 0)
                    read_window("R5 data", 1'b0, '0);
                else if ((2 * n_out) % DEPTH + TAPS > DEPTH)
                    read_window("R8 data", 1'b0, '0);
                else
                    read_window("R7 data", 1'b0, '0);
            end
        end
        chk("R3 no overflow yet", int'(ovf_err), 0);

        // R10: write during a window read
        do_write(16'h1111);
        read_window("R10 data", 1'b1, 16'hA5A5);
        do_write(16'h0F0F);
        chk("R10 ready", int'(ready), 1);
        read_window("R10 data", 1'b0, '0);

        // R3: overflow drops the sample and latches the flag
        do_reset();
        for (int i = 0; i < TAPS; i++) do_write(16'h0100 + 16'(i));
        chk("R3 full no flag", int'(ovf_err), 0);
        do_write(16'hDEAD);
        chk("R3 flag set", int'(ovf_err), 1);
        read_window("R5 data after fill", 1'b0, '0);
        chk("R3 flag held", int'(ovf_err), 1);
        for (int j = 0; j < 4; j++) read_window("R3 data", 1'b0, '0);

        // R2: write position wraps to entry 0
        do_write(16'h7E01);
        do_write(16'h7E02);
        chk("R2 ready", int'(ready), 1);
        read_window("R2 data", 1'b0, '0);
        chk("R3 flag still held", int'(ovf_err), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule